// File: doc/BRIEF.md
# CPU Bank-Switching Address Mapper

This block sits between a CPU's 16-bit address bus and the program ROM and cartridge RAM. It turns each CPU access into a physical ROM or RAM address with one chip select. The 32 KB program window at 0x8000-0xFFFF is split into equal slots. Each slot holds a registered page number and an access permission. A separate select port loads a page into a slot, loads two consecutive pages into two neighbouring slots, or removes a slot's mapping.

Page numbers wrap modulo the image's page count, and that count need not be a power of two. Negative numbers count back from the last page. When the program image is smaller than one slot, it repeats across the whole window. The 8 KB RAM window at 0x6000-0x7FFF selects save RAM when a battery is fitted, and work RAM otherwise. A CPU write into the program window is sent to a neighbouring register decoder as a write strobe. With conflict emulation on, the written byte is ANDed with the ROM byte under it. Any read that no page serves returns the last byte seen on the data bus.

Top module: `cpu_bank_mapper`

## Requirements
- R1: After reset every program slot has no access: a read anywhere in 0x8000-0xFFFF keeps `rom_cs` low and returns the open-bus value, which resets to 0x00.
- R2: A select with bank number n >= 0 maps slot s (covering 0x8000 + s*PAGE_BYTES) to page n mod COUNT from the next cycle on, where COUNT = PRG_BYTES/PAGE_BYTES (default 6). A read there raises `rom_cs` with `mem_addr` = page*PAGE_BYTES + (address mod PAGE_BYTES).
- R3: A bank number from -COUNT to -1, in 8-bit two's complement, selects page COUNT + n.
- R4: A select with `sel_pair` set also maps slot s+1 to the page after slot s's page, and that page wraps from COUNT-1 to 0. On the last slot the second half is dropped.
- R5: A select with `sel_unmap` set removes slot s's access. Later reads there return the open-bus value with `rom_cs` low, and the bank number is ignored.
- R6: 0x6000-0x7FFF is read-write RAM with `mem_addr` = address mod 8192. `save_cs` is used when HAS_BATTERY is set and save RAM exists, `work_cs` otherwise, and `ram_we` marks writes.
- R7: The open-bus register loads the read data on each read and `cpu_wdata` on each write. Accesses below 0x6000 raise no chip select, and reads there return that register.
- R8: A write to 0x8000-0xFFFF raises `reg_we` in the same cycle and raises no RAM select. With `conflict_en` low, `reg_wdata` equals `cpu_wdata`.
- R9: With `conflict_en` high and the slot readable, such a write also raises `rom_cs` at the mapped address, and `reg_wdata` = `cpu_wdata` AND `rom_rdata`. On an unmapped slot the byte passes through unchanged.
- R10: When PRG_BYTES < PAGE_BYTES, any non-unmap select makes every slot readable, and the ROM address becomes (address - 0x8000) mod PRG_BYTES.
- R11: A select and a CPU access in the same cycle: the access uses the mapping from before the select.
- R12: At most one of `rom_cs`, `save_cs`, `work_cs` is high, and only while `cpu_rd` or `cpu_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conflict_en | input | 1 | Enable write bus-conflict emulation |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| sel_valid | input | 1 | Bank select command valid |
| sel_slot | input | SLOT_W | Target program slot |
| sel_bank | input | BANK_W | Signed bank number |
| sel_pair | input | 1 | Also map the next slot to the next page |
| sel_unmap | input | 1 | Remove the slot's mapping |
| rom_rdata | input | 8 | Byte from program ROM at `mem_addr` |
| ram_rdata | input | 8 | Byte from the selected RAM at `mem_addr` |
| mem_addr | output | PHYS_W | Physical ROM or RAM address |
| rom_cs | output | 1 | Program ROM select |
| save_cs | output | 1 | Save RAM select |
| work_cs | output | 1 | Work RAM select |
| ram_we | output | 1 | RAM write enable |
| reg_we | output | 1 | Register-window write strobe |
| reg_wdata | output | 8 | Register write byte, conflict-adjusted |
| cpu_rdata | output | 8 | Read data to the CPU |

## Verification
Two things can land in one cycle. A bank select can arrive together with a CPU access to the slot it retargets. A register write can arrive while the ROM is being read for the conflict AND. Directed cycles drive a select and a read to the same slot together, then read again on the next cycle. Register writes go to mapped and unmapped slots with conflict emulation both on and off, and a random phase mixes selects with accesses. A behavioural model applies each select only after it has compared that cycle, so a design that lets the new mapping leak into the same cycle shows up as a mismatch.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_RD   = 2'b01,
    ACC_WR   = 2'b10,
    ACC_RW   = 2'b11
  } acc_e;

  function automatic logic acc_can_read(input acc_e a);
    return a[0];
  endfunction
endpackage

// File: rtl/mapper_bank_wrap.sv
module mapper_bank_wrap #(
  parameter int COUNT  = 6,
  parameter int BANK_W = 8,
  parameter int PG_W   = 3
) (
  input  logic [BANK_W-1:0] bank_i,
  output logic [PG_W-1:0]   page_o,
  output logic [PG_W-1:0]   next_o
);
  int signed_bank;
  int wrapped;

  always_comb begin
    signed_bank = int'($signed(bank_i));
    // true modulo: negative numbers count back from the last page
    wrapped = ((signed_bank % COUNT) + COUNT) % COUNT;
    page_o  = PG_W'(wrapped);
    next_o  = (wrapped + 1 == COUNT) ? '0 : PG_W'(wrapped + 1);
  end
endmodule

// File: rtl/mapper_slot_table.sv
module mapper_slot_table import mapper_pkg::*; #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 2,
  parameter int PG_W   = 3,
  parameter int COUNT  = 6,
  parameter bit MIRROR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  logic [SLOT_W-1:0] sel_slot,
  input  logic              sel_pair,
  input  logic              sel_unmap,
  input  logic [PG_W-1:0]   page_i,
  input  logic [PG_W-1:0]   next_i,
  output logic [PG_W-1:0]   page_o [SLOTS],
  output acc_e              acc_o  [SLOTS]
);
  logic [PG_W-1:0] page_q [SLOTS];
  logic [PG_W-1:0] page_d [SLOTS];
  acc_e            acc_q  [SLOTS];
  acc_e            acc_d  [SLOTS];
  logic [SLOT_W-1:0] pair_slot;

  assign pair_slot = sel_slot + SLOT_W'(1);

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      page_d[i] = page_q[i];
      acc_d[i]  = acc_q[i];
    end
    if (sel_valid) begin
      if (sel_unmap) begin
        acc_d[sel_slot] = ACC_NONE;
      end else if (MIRROR) begin
        for (int i = 0; i < SLOTS; i++) acc_d[i] = ACC_RD;
      end else begin
        page_d[sel_slot] = page_i;
        acc_d[sel_slot]  = ACC_RD;
        if (sel_pair && (sel_slot != SLOT_W'(SLOTS - 1))) begin
          page_d[pair_slot] = next_i;
          acc_d[pair_slot]  = ACC_RD;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        page_q[i] <= '0;
        acc_q[i]  <= ACC_NONE;
      end
    end else if (sel_valid) begin
      for (int i = 0; i < SLOTS; i++) begin
        page_q[i] <= page_d[i];
        acc_q[i]  <= acc_d[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      page_o[i] = page_q[i];
      acc_o[i]  = acc_q[i];
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_chk
    p_map_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && !sel_unmap && sel_slot == SLOT_W'(g)) |=> acc_q[g] == ACC_RD);
    p_unmap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && sel_unmap && sel_slot == SLOT_W'(g)) |=> acc_q[g] == ACC_NONE);
    p_page_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(page_q[g]) < COUNT);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |=> ($stable(acc_q[g]) && $stable(page_q[g])));
  end
endmodule

// File: rtl/cpu_bank_mapper.sv
module cpu_bank_mapper import mapper_pkg::*; #(
  parameter int          PAGE_BYTES  = 8192,
  parameter int          PRG_BYTES   = 49152,
  parameter int          SAVE_BYTES  = 8192,
  parameter int          WORK_BYTES  = 8192,
  parameter bit          HAS_BATTERY = 1'b1,
  parameter int          BANK_W      = 8,
  parameter logic [15:0] RAM_BASE    = 16'h6000,
  parameter logic [15:0] ROM_BASE    = 16'h8000,
  localparam int WIN_AW    = 15,
  localparam int SLOTS     = (1 << WIN_AW) / PAGE_BYTES,
  localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int PAGE_AW   = $clog2(PAGE_BYTES),
  localparam bit MIRROR    = (PRG_BYTES < PAGE_BYTES),
  localparam int COUNT     = MIRROR ? 1 : PRG_BYTES / PAGE_BYTES,
  localparam int PG_W      = (COUNT > 1) ? $clog2(COUNT) : 1,
  localparam int ROM_AW    = $clog2(PRG_BYTES),
  localparam bit USE_SAVE  = HAS_BATTERY && (SAVE_BYTES > 0),
  localparam bit USE_WORK  = !USE_SAVE && (WORK_BYTES > 0),
  localparam int RAM_BYTES = USE_SAVE ? SAVE_BYTES : (USE_WORK ? WORK_BYTES : 2),
  localparam int RAM_AW    = $clog2(RAM_BYTES),
  localparam int PHYS_W    = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conflict_en,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              sel_valid,
  input  logic [SLOT_W-1:0] sel_slot,
  input  logic [BANK_W-1:0] sel_bank,
  input  logic              sel_pair,
  input  logic              sel_unmap,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              rom_cs,
  output logic              save_cs,
  output logic              work_cs,
  output logic              ram_we,
  output logic              reg_we,
  output logic [7:0]        reg_wdata,
  output logic [7:0]        cpu_rdata
);
  logic [PG_W-1:0]   wrap_page, wrap_next;
  logic [PG_W-1:0]   slot_page [SLOTS];
  acc_e              slot_acc  [SLOTS];
  logic [WIN_AW-1:0] rom_off;
  logic [SLOT_W-1:0] slot_idx;
  logic              in_rom, in_ram, slot_rd, ram_hit;
  logic [ROM_AW-1:0] rom_phys;
  logic [RAM_AW-1:0] ram_phys;
  logic [7:0]        obus_q, obus_d;

  mapper_bank_wrap #(.COUNT(COUNT), .BANK_W(BANK_W), .PG_W(PG_W)) u_wrap (
    .bank_i (sel_bank),
    .page_o (wrap_page),
    .next_o (wrap_next)
  );

  mapper_slot_table #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .PG_W(PG_W),
                      .COUNT(COUNT), .MIRROR(MIRROR)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_valid (sel_valid),
    .sel_slot  (sel_slot),
    .sel_pair  (sel_pair),
    .sel_unmap (sel_unmap),
    .page_i    (wrap_page),
    .next_i    (wrap_next),
    .page_o    (slot_page),
    .acc_o     (slot_acc)
  );

  // address decode
  assign in_rom   = (cpu_addr >= ROM_BASE);
  assign in_ram   = (cpu_addr >= RAM_BASE) && (cpu_addr < ROM_BASE);
  assign rom_off  = WIN_AW'(cpu_addr - ROM_BASE);
  assign slot_idx = SLOT_W'(rom_off >> PAGE_AW);
  assign slot_rd  = in_rom && acc_can_read(slot_acc[slot_idx]);
  assign ram_phys = cpu_addr[RAM_AW-1:0];

  if (MIRROR) begin : g_mirror
    assign rom_phys = ROM_AW'(32'(rom_off) % PRG_BYTES);
  end else begin : g_banked
    assign rom_phys = ROM_AW'({slot_page[slot_idx], rom_off[PAGE_AW-1:0]});
  end

  if (USE_SAVE || USE_WORK) begin : g_ram
    assign ram_hit = in_ram && (cpu_rd || cpu_wr);
  end else begin : g_no_ram
    assign ram_hit = 1'b0;
  end

  assign save_cs = USE_SAVE ? ram_hit : 1'b0;
  assign work_cs = USE_WORK ? ram_hit : 1'b0;
  assign ram_we  = ram_hit && cpu_wr;

  // ROM is read on reads and, for conflict emulation, on register writes
  assign rom_cs  = slot_rd && (cpu_rd || (cpu_wr && conflict_en));

  always_comb begin
    if (rom_cs)       mem_addr = PHYS_W'(rom_phys);
    else if (ram_hit) mem_addr = PHYS_W'(ram_phys);
    else              mem_addr = '0;
  end

  assign reg_we    = cpu_wr && in_rom;
  assign reg_wdata = (conflict_en && slot_rd) ? (cpu_wdata & rom_rdata) : cpu_wdata;

  always_comb begin
    if (slot_rd)      cpu_rdata = rom_rdata;
    else if (ram_hit) cpu_rdata = ram_rdata;
    else              cpu_rdata = obus_q;
  end

  // open-bus latch: last byte seen on the data bus
  always_comb begin
    obus_d = obus_q;
    if (cpu_wr)      obus_d = cpu_wdata;
    else if (cpu_rd) obus_d = cpu_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                obus_q <= '0;
    else if (cpu_rd || cpu_wr) obus_q <= obus_d;
  end

  p_cs_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, save_cs, work_cs}));
  p_cs_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs || save_cs || work_cs) |-> (cpu_rd || cpu_wr));
  p_obus_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> obus_q == $past(cpu_wdata));
  p_obus_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr) |=> obus_q == $past(cpu_rdata));
  p_reg_no_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (!save_cs && !work_cs && !ram_we));
  p_conflict_and_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && conflict_en && rom_cs) |-> ((reg_wdata & ~rom_rdata) == 8'h00));
endmodule

// File: tb/test_cpu_bank_mapper.sv
module test_cpu_bank_mapper;
  logic clk = 1'b0;
  logic rst_n;
  logic conflict_en, cpu_rd, cpu_wr, sel_valid, sel_pair, sel_unmap;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, sel_bank;
  logic [1:0]  sel_slot;

  always #4 clk = ~clk;

  logic [15:0] m0_addr;
  logic [12:0] m1_addr;
  logic [7:0]  rom_rd [2], ram_rd [2], rdata [2], rwd [2];
  logic        rcs [2], scs [2], wcs [2], rwe [2], rgwe [2];
  logic [7:0]  sram [2][8192];
  int checks = 0, failures = 0;

  function automatic logic [7:0] romb(input int a);
    return 8'((a * 29 + 7) ^ (a >> 8));
  endfunction

  assign rom_rd[0] = romb(int'(m0_addr));
  assign rom_rd[1] = romb(int'(m1_addr));
  assign ram_rd[0] = sram[0][m0_addr[12:0]];
  assign ram_rd[1] = sram[1][m1_addr];

  cpu_bank_mapper i_cpu_bank_mapper (
    .clk(clk), .rst_n(rst_n), .conflict_en(conflict_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .sel_valid(sel_valid),
    .sel_slot(sel_slot), .sel_bank(sel_bank), .sel_pair(sel_pair), .sel_unmap(sel_unmap),
    .rom_rdata(rom_rd[0]), .ram_rdata(ram_rd[0]), .mem_addr(m0_addr), .rom_cs(rcs[0]),
    .save_cs(scs[0]), .work_cs(wcs[0]), .ram_we(rwe[0]), .reg_we(rgwe[0]),
    .reg_wdata(rwd[0]), .cpu_rdata(rdata[0]));

  cpu_bank_mapper #(.PRG_BYTES(4096), .HAS_BATTERY(1'b0)) i_cpu_bank_mapper_mirror (
    .clk(clk), .rst_n(rst_n), .conflict_en(conflict_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .sel_valid(sel_valid),
    .sel_slot(sel_slot), .sel_bank(sel_bank), .sel_pair(sel_pair), .sel_unmap(sel_unmap),
    .rom_rdata(rom_rd[1]), .ram_rdata(ram_rd[1]), .mem_addr(m1_addr), .rom_cs(rcs[1]),
    .save_cs(scs[1]), .work_cs(wcs[1]), .ram_we(rwe[1]), .reg_we(rgwe[1]),
    .reg_wdata(rwd[1]), .cpu_rdata(rdata[1]));

  always @(posedge clk) begin
    if (rwe[0]) sram[0][m0_addr[12:0]] <= cpu_wdata;
    if (rwe[1]) sram[1][m1_addr] <= cpu_wdata;
  end

  // reference model state
  int  cnt [2]  = '{6, 1};
  int  prgb [2] = '{49152, 4096};
  bit  mir [2]  = '{1'b0, 1'b1};
  bit  batt [2] = '{1'b1, 1'b0};
  int  mp [2][4];
  bit  ma [2][4];
  int  ob [2];

  task automatic chk(input string tag, input string what, input int k, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s dut%0d %s: actual=%0h expected=%0h", tag, k, what, act, exp);
    end
  endtask

  task automatic check_commit(input string tag);
    for (int k = 0; k < 2; k++) begin
      int a = int'(cpu_addr);
      int wd = int'(cpu_wdata);
      bit in_rom = (a >= 32768);
      bit in_ram = (a >= 24576) && (a < 32768);
      int s = in_rom ? (a - 32768) / 8192 : 0;
      bit rd_ok = in_rom && ma[k][s];
      int phys = mir[k] ? (a - 32768) % prgb[k] : mp[k][s] * 8192 + a % 8192;
      bit e_rcs = rd_ok && (cpu_rd || (cpu_wr && conflict_en));
      bit e_ram = in_ram && (cpu_rd || cpu_wr);
      int e_rd = rd_ok ? int'(romb(phys)) : (e_ram ? int'(sram[k][a % 8192]) : ob[k]);
      bit e_rgwe = cpu_wr && in_rom;
      int e_rwd = (conflict_en && rd_ok) ? (wd & int'(romb(phys))) : wd;
      int act_addr = (k == 0) ? int'(m0_addr) : int'(m1_addr);
      chk(tag, "rom_cs", k, int'(rcs[k]), int'(e_rcs));
      chk(tag, "save_cs", k, int'(scs[k]), int'(e_ram && batt[k]));
      chk(tag, "work_cs", k, int'(wcs[k]), int'(e_ram && !batt[k]));
      chk(tag, "ram_we", k, int'(rwe[k]), int'(e_ram && cpu_wr));
      chk(tag, "reg_we", k, int'(rgwe[k]), int'(e_rgwe));
      if (e_rcs)   chk(tag, "mem_addr", k, act_addr, phys);
      if (e_ram)   chk(tag, "mem_addr", k, act_addr, a % 8192);
      if (cpu_rd)  chk(tag, "cpu_rdata", k, int'(rdata[k]), e_rd);
      if (e_rgwe)  chk(tag, "reg_wdata", k, int'(rwd[k]), e_rwd);
      // commit for next cycle
      if (cpu_wr) ob[k] = wd;
      else if (cpu_rd) ob[k] = e_rd;
      if (sel_valid) begin
        int ss = int'(sel_slot);
        int b = int'($signed(sel_bank));
        int p = ((b % cnt[k]) + cnt[k]) % cnt[k];
        if (sel_unmap) ma[k][ss] = 1'b0;
        else if (mir[k]) for (int i = 0; i < 4; i++) ma[k][i] = 1'b1;
        else begin
          mp[k][ss] = p; ma[k][ss] = 1'b1;
          if (sel_pair && ss < 3) begin
            mp[k][ss+1] = (p + 1) % cnt[k]; ma[k][ss+1] = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic op(input string tag, input bit rd, input bit wr, input int a, input int wd,
                    input bit ce = 1'b0, input bit sv = 1'b0, input int ss = 0, input int sb = 0,
                    input bit sp = 1'b0, input bit su = 1'b0);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a[15:0]; cpu_wdata = wd[7:0]; conflict_en = ce;
    sel_valid = sv; sel_slot = ss[1:0]; sel_bank = sb[7:0]; sel_pair = sp; sel_unmap = su;
    #2;
    check_commit(tag);
  endtask

  task automatic sel(input string tag, input int ss, input int sb, input bit sp = 1'b0, input bit su = 1'b0);
    op(tag, 1'b0, 1'b0, 16'h5000, 0, 1'b0, 1'b1, ss, sb, sp, su);
  endtask

  task automatic rd(input string tag, input int a);
    op(tag, 1'b1, 1'b0, a, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R12: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      ob[k] = 0;
      for (int i = 0; i < 4; i++) begin mp[k][i] = 0; ma[k][i] = 1'b0; end
      for (int i = 0; i < 8192; i++) sram[k][i] = i[7:0];
    end
    rst_n = 1'b0; cpu_rd = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0; conflict_en = 0;
    sel_valid = 0; sel_slot = 0; sel_bank = 0; sel_pair = 0; sel_unmap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    rd("R1", 16'h8000);                         // unmapped: open bus 0
    rd("R1", 16'hC123);
    rd("R7", 16'h5000);                         // below RAM window
    op("R6", 1'b0, 1'b1, 16'h6010, 8'h5A);      // RAM write
    rd("R6", 16'h6010);                         // read back, open bus follows
    rd("R7", 16'h4100);
    sel("R2", 0, 2);
    rd("R2", 16'h8004);
    sel("R2", 3, 9);                            // 9 mod 6 = 3
    rd("R2", 16'hE001);
    rd("R10", 16'h9234);                        // mirror image repeats
    sel("R3", 1, -1);                           // page 5
    rd("R3", 16'hA0FF);
    sel("R3", 1, -6);                           // page 0
    rd("R3", 16'hA001);
    sel("R4", 2, 5, 1'b1);                      // slot2=5, slot3 wraps to 0
    rd("R4", 16'hC010);
    rd("R4", 16'hE010);
    sel("R4", 3, 1, 1'b1);                      // last slot: pair dropped
    rd("R4", 16'hE020);
    sel("R5", 1, 4, 1'b0, 1'b1);                // unmap slot1
    rd("R5", 16'hA000);
    op("R8", 1'b0, 1'b1, 16'h8100, 8'hF0, 1'b0);
    op("R9", 1'b0, 1'b1, 16'h8100, 8'hF0, 1'b1);
    op("R9", 1'b0, 1'b1, 16'hA000, 8'h3C, 1'b1); // unmapped slot: no AND
    op("R7", 1'b0, 1'b1, 16'h4100, 8'hA7);
    rd("R7", 16'h4100);
    op("R11", 1'b1, 1'b0, 16'h8000, 0, 1'b0, 1'b1, 0, 4); // old mapping this cycle
    rd("R11", 16'h8000);                        // new mapping
    op("R6", 1'b0, 1'b1, 16'h7FFF, 8'h11);
    rd("R6", 16'h7FFF);

    for (int n = 0; n < 600; n++) begin
      int kind = int'($urandom_range(0, 5));
      int a = int'($urandom_range(16'h4000, 16'hFFFF));
      int wd = int'($urandom_range(0, 255));
      bit ce = 1'($urandom_range(0, 1));
      int ss = int'($urandom_range(0, 3));
      int sb = int'($urandom_range(0, 106)) - 6;
      case (kind)
        0: op("R12", 1'b0, 1'b0, a, wd, ce, 1'b1, ss, sb, 1'($urandom_range(0, 1)),
              ($urandom_range(0, 4) == 0));
        1, 2: op("R12", 1'b1, 1'b0, a, wd, ce);
        3: op("R12", 1'b0, 1'b1, a, wd, ce);
        4: op("R11", 1'b1, 1'b0, a, wd, ce, 1'b1, ss, sb, 1'b0, 1'b0);
        default: op("R12", 1'b0, 1'b0, a, wd, ce);
      endcase
    end
    op("R12", 1'b0, 1'b0, 16'h5000, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule